// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

An eight-pin general-purpose I/O port attached to a small register bus. Software sees three registers: a drive-value register, a direction register and a read-only level register that returns the pad levels. For each pin the block produces an output enable, an output value and a pull-up enable. A write of ones to the level register flips the matching drive-value bits. This lets software toggle pins without a read-modify-write.

Pad levels pass through a two-flop synchroniser before the level register can return them. A system-wide pull-up kill input turns off every pull-up at once. Each pin also has an override hook. A peripheral uses it to take over that pin's output enable and value, and the other pins are not affected.

Top module: `gpio_port`

## Requirements
- R1: The drive-value register sits at address 2 and the direction register at address 1. Both are read/write, and a read returns the last value written.
- R2: The level register at address 0 is read-only. Writing zeros there changes neither the drive-value register nor the value that address 0 reads back.
- R3: Writing a word with bit n set to address 0 inverts bit n of the drive-value register. Bits written as zero keep their value.
- R4: When a pin has no override, its output enable equals its direction bit (1 = output) and its output value equals its drive-value bit.
- R5: A pin's pull-up is on exactly when its effective direction is 0, its effective drive value is 1 and the global pull-up kill input is low.
- R6: While the global pull-up kill input is high, every pull-up output is 0.
- R7: A read of address 0 shows a pad change after two rising clock edges. After only one edge it still shows the old level.
- R8: Synchronous active-high reset clears both registers and the synchroniser. After reset every pin is an input with no pull-up.
- R9: When a pin's override bit is 1, the supplied override enable and value replace that pin's direction and drive-value bits. Pins without override keep their register behaviour.
- R10: Address 3 is unmapped. It reads as zero and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register address |
| reg_wen | input | 1 | Write strobe, sampled at the rising edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| pull_kill | input | 1 | Global pull-up disable |
| pad_in | input | 8 | Asynchronous pad levels |
| ovr_en | input | 8 | Per-pin override select |
| ovr_oe | input | 8 | Override output enable |
| ovr_val | input | 8 | Override output value |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output value |
| pad_pull | output | 8 | Per-pin pull-up enable |

## Verification
The bench writes a mixed pattern to the toggle address. A design that stored the written word, or XORed with the wrong operand, shows the wrong drive value. A write of all zeros there would clear the register in a design that treated the address as writable. The bench samples the level register one edge and two edges after a pad change. A design with one synchroniser stage too many or too few reads the new level at the wrong moment. A single-pin override is checked against its neighbours and against the pull-up output. A design that leaked the override or computed the pull-up from the raw register bits would show a wrong enable on some pin.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_LVL  = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_OUT  = 2'd2,
        SEL_NONE = 2'd3
    } sel_e;

    // One-hot write strobes produced by the address decoder
    typedef struct packed {
        logic lvl;
        logic dir;
        logic out;
    } strobe_t;

    function automatic strobe_t decode_wr(input logic [ADDR_W-1:0] addr, input logic wen);
        strobe_t s;
        s = '0;
        if (wen) begin
            unique case (sel_e'(addr))
                SEL_LVL:  s.lvl = 1'b1;
                SEL_DIR:  s.dir = 1'b1;
                SEL_OUT:  s.out = 1'b1;
                default:  s = '0;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int CW = $clog2(STAGES + 1);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[s] <= '0;
            else     stg[s] <= stg[s-1];
        end
    end

    assign dout = stg[STAGES-1];

    // Cycles since reset, saturating, so the latency check never looks before reset
    logic [CW-1:0] warm;
    always_ff @(posedge clk) begin
        if (rst)                    warm <= '0;
        else if (warm != CW'(STAGES)) warm <= warm + 1'b1;
    end

    if (STAGES == 2) begin : g_lat_chk
        // R7
        sync_latency_chk: assert property (@(posedge clk) disable iff (rst)
            (warm == CW'(STAGES)) |-> (dout == $past(din, 2)));
    end

    // R8
    sync_reset_chk: assert property (@(posedge clk)
        $past(rst) |-> (dout == '0));

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  strobe_t      stb,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] out_q,
    output logic [W-1:0] dir_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '0;
        end else if (stb.dir) begin
            dir_q <= wdata;
        end
    end

    // A direct write wins over a toggle write
    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else if (stb.out) begin
            out_q <= wdata;
        end else if (stb.lvl) begin
            out_q <= out_q ^ wdata;
        end
    end

    // R3
    toggle_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (stb.lvl && !stb.out) |=> (out_q == ($past(out_q) ^ $past(wdata))));

    // R1
    dir_write_chk: assert property (@(posedge clk) disable iff (rst)
        stb.dir |=> (dir_q == $past(wdata)));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (stb == '0) |=> ($stable(out_q) && $stable(dir_q)));

    // R8
    regs_reset_chk: assert property (@(posedge clk)
        $past(rst) |-> (out_q == '0 && dir_q == '0));

    strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(stb));

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] out_q,
    input  logic [W-1:0] ovr_en,
    input  logic [W-1:0] ovr_oe,
    input  logic [W-1:0] ovr_val,
    input  logic         pull_kill,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_pull
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        logic eff_oe;
        logic eff_val;

        always_comb begin
            if (ovr_en[i]) begin
                eff_oe  = ovr_oe[i];
                eff_val = ovr_val[i];
            end else begin
                eff_oe  = dir_q[i];
                eff_val = out_q[i];
            end
        end

        assign pad_oe[i]   = eff_oe;
        assign pad_out[i]  = eff_val;
        assign pad_pull[i] = !eff_oe && eff_val && !pull_kill;

        // R4
        plain_pin_chk: assert property (@(posedge clk) disable iff (rst)
            !ovr_en[i] |-> (pad_oe[i] == dir_q[i] && pad_out[i] == out_q[i]));

        // R9
        ovr_pin_chk: assert property (@(posedge clk) disable iff (rst)
            ovr_en[i] |-> (pad_oe[i] == ovr_oe[i] && pad_out[i] == ovr_val[i]));

        // R5
        pull_driver_chk: assert property (@(posedge clk) disable iff (rst)
            pad_pull[i] |-> (!pad_oe[i] && pad_out[i]));
    end

    // R6
    pull_kill_chk: assert property (@(posedge clk) disable iff (rst)
        pull_kill |-> (pad_pull == '0));

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wen,
    input  logic [W-1:0]      reg_wdata,
    output logic [W-1:0]      reg_rdata,
    input  logic              pull_kill,
    input  logic [W-1:0]      pad_in,
    input  logic [W-1:0]      ovr_en,
    input  logic [W-1:0]      ovr_oe,
    input  logic [W-1:0]      ovr_val,
    output logic [W-1:0]      pad_oe,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_pull
);
    strobe_t      stb;
    logic [W-1:0] out_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] lvl_s;

    assign stb = decode_wr(reg_addr, reg_wen);

    gpio_regs #(.W(W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .stb   (stb),
        .wdata (reg_wdata),
        .out_q (out_q),
        .dir_q (dir_q)
    );

    gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pad_in),
        .dout (lvl_s)
    );

    gpio_pad_ctrl #(.W(W)) u_pad (
        .clk       (clk),
        .rst       (rst),
        .dir_q     (dir_q),
        .out_q     (out_q),
        .ovr_en    (ovr_en),
        .ovr_oe    (ovr_oe),
        .ovr_val   (ovr_val),
        .pull_kill (pull_kill),
        .pad_oe    (pad_oe),
        .pad_out   (pad_out),
        .pad_pull  (pad_pull)
    );

    always_comb begin
        unique case (sel_e'(reg_addr))
            SEL_LVL: reg_rdata = lvl_s;
            SEL_DIR: reg_rdata = dir_q;
            SEL_OUT: reg_rdata = out_q;
            default: reg_rdata = '0;
        endcase
    end

    // R10
    unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == SEL_NONE) |-> (reg_rdata == '0));

    // R2
    lvl_zero_write_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wen && reg_addr == SEL_LVL && reg_wdata == '0) |=> $stable(out_q));

endmodule

// File: tb/sim_gpio_port.sv
module sim_gpio_port;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   reg_addr = 2'd0;
    logic         reg_wen = 1'b0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] reg_rdata;
    logic         pull_kill = 1'b0;
    logic [W-1:0] pad_in = '0;
    logic [W-1:0] ovr_en = '0;
    logic [W-1:0] ovr_oe = '0;
    logic [W-1:0] ovr_val = '0;
    logic [W-1:0] pad_oe;
    logic [W-1:0] pad_out;
    logic [W-1:0] pad_pull;

    always #2 clk = ~clk;

    gpio_port u0 (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wen   (reg_wen),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pull_kill (pull_kill),
        .pad_in    (pad_in),
        .ovr_en    (ovr_en),
        .ovr_oe    (ovr_oe),
        .ovr_val   (ovr_val),
        .pad_oe    (pad_oe),
        .pad_out   (pad_out),
        .pad_pull  (pad_pull)
    );

    // Which output an expected item is compared against
    typedef enum int { SRC_RD, SRC_OE, SRC_OUT, SRC_PULL } src_e;

    typedef struct {
        string      req;
        src_e       src;
        logic [7:0] exp;
    } item_t;

    item_t queue_q[$];
    event  chk_ev;
    int    n_vec  = 0;
    int    n_fail = 0;
    bit    done   = 0;

    task automatic push(input string req, input src_e src, input logic [7:0] exp);
        item_t it;
        it.req = req;
        it.src = src;
        it.exp = exp;
        queue_q.push_back(it);
        -> chk_ev;
        #1;
    endtask

    // Monitor: pops expected items and compares against the live outputs
    initial begin
        forever begin
            @(chk_ev);
            while (queue_q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = queue_q.pop_front();
                case (it.src)
                    SRC_RD:  act = reg_rdata;
                    SRC_OE:  act = pad_oe;
                    SRC_OUT: act = pad_out;
                    default: act = pad_pull;
                endcase
                n_vec++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s src=%0d actual=%02h expected=%02h", it.req, it.src, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wen   = 1'b1;
        @(posedge clk);
        #1;
        reg_wen = 1'b0;
    endtask

    task automatic rd_expect(input string req, input logic [1:0] a, input logic [7:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        push(req, SRC_RD, exp);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R8: reset state
        rd_expect("R8", 2'd1, 8'h00);
        rd_expect("R8", 2'd2, 8'h00);
        rd_expect("R8", 2'd0, 8'h00);
        push("R8", SRC_OE, 8'h00);
        push("R8", SRC_PULL, 8'h00);

        // R1: write and read back both registers
        wr(2'd1, 8'hF0);
        wr(2'd2, 8'h3C);
        rd_expect("R1", 2'd1, 8'hF0);
        rd_expect("R1", 2'd2, 8'h3C);

        // R4 / R5: pad outputs follow registers
        push("R4", SRC_OE, 8'hF0);
        push("R4", SRC_OUT, 8'h3C);
        push("R5", SRC_PULL, 8'h0C);

        // R6: global kill
        @(negedge clk);
        pull_kill = 1'b1;
        #1;
        push("R6", SRC_PULL, 8'h00);
        @(negedge clk);
        pull_kill = 1'b0;
        #1;
        push("R5", SRC_PULL, 8'h0C);

        // R3: toggle by writing ones to the level address
        wr(2'd0, 8'h81);
        rd_expect("R3", 2'd2, 8'hBD);
        push("R3", SRC_OUT, 8'hBD);

        // R2: zeros at the level address leave everything alone
        wr(2'd0, 8'h00);
        rd_expect("R2", 2'd2, 8'hBD);
        rd_expect("R2", 2'd0, 8'h00);

        // R10: unmapped address
        wr(2'd3, 8'hFF);
        rd_expect("R10", 2'd3, 8'h00);
        rd_expect("R10", 2'd1, 8'hF0);
        rd_expect("R10", 2'd2, 8'hBD);

        // R7: two-edge synchroniser latency
        @(negedge clk);
        reg_addr = 2'd0;
        pad_in   = 8'hA5;
        @(negedge clk);
        #1;
        push("R7", SRC_RD, 8'h00);
        @(negedge clk);
        #1;
        push("R7", SRC_RD, 8'hA5);
        @(negedge clk);
        pad_in = 8'h5A;
        @(negedge clk);
        #1;
        push("R7", SRC_RD, 8'hA5);
        @(negedge clk);
        #1;
        push("R7", SRC_RD, 8'h5A);

        // R9: override pin 0 only
        @(negedge clk);
        ovr_en  = 8'h01;
        ovr_oe  = 8'h01;
        ovr_val = 8'h00;
        #1;
        push("R9", SRC_OE, 8'hF1);
        push("R9", SRC_OUT, 8'hBC);
        push("R9", SRC_PULL, 8'h0C);

        // R9: override pin 1 as pulled input, registers unchanged
        @(negedge clk);
        ovr_en  = 8'h02;
        ovr_oe  = 8'h00;
        ovr_val = 8'h02;
        #1;
        push("R9", SRC_OE, 8'hF0);
        push("R9", SRC_OUT, 8'hBF);
        push("R9", SRC_PULL, 8'h0F);
        rd_expect("R9", 2'd2, 8'hBD);

        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule